// File: doc/BRIEF.md
# Programmable Priority Interrupt Resolver

This block picks, from forty interrupt sources, the single most urgent source that should be delivered on the fast interrupt line and, separately, the most urgent source for the normal interrupt line. Urgency does not follow the source number. Forty priority slots decide it. Each slot may point at any source. Slot 0 is the most urgent and slot 39 the least.

A source is active when it is pending and enabled. Its select bit then routes it to either the fast class or the normal class. The two winners are packed into one 32-bit result word, each half carrying its own valid flag. When a half has no winner, its identifier field reads all ones. The resolver logic is combinational. A parameter adds a result register, which is the default, so the word then follows its inputs with one clock of latency. The register resets to the "no winner" word.

Top module: `prio_resolver`

## Requirements
- R1: A slot word takes part in resolution only when its bit 31 (the valid flag) is 1. A slot with bit 31 clear never wins, even if the source it names is active.
- R2: A valid slot whose identifier (bits 5:0) is 40 or above never wins.
- R3: Among all slots that match for a class, the one with the lowest slot number wins.
- R4: A slot matches the fast class when its source has pending=1, enable=1 and select=1. A pending source whose enable is 0 matches neither class.
- R5: A slot matches the normal class when its source has pending=1, enable=1 and select=0.
- R6: The fast winner is reported with result bit 15 = 1 and its identifier in result bits 5:0.
- R7: The normal winner is reported with result bit 31 = 1 and its identifier in result bits 21:16.
- R8: A class with no winner reports its valid bit as 0 and its identifier field as 0x3F. With no winner in either class, the result is 0x003F003F.
- R9: The two classes are resolved independently. Adding or removing a winner in one class leaves the other half of the word unchanged.
- R10: Result bits 14:6 and 30:22 are always 0.
- R11: When two slots name the same source, the lower-numbered slot wins and no error is raised. A source named only by a less urgent slot loses to it.
- R12: With the result register enabled, the result word reflects its inputs one clock edge after they change. While rst is high, and on the first edge after reset, the result word is 0x003F003F.
- R13: Slot word bits 30:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset of the result register |
| pend_i | input | 40 | Pending flag per source |
| en_i | input | 40 | Enable flag per source |
| fast_sel_i | input | 40 | 1 routes the source to the fast class, 0 to the normal class |
| slot_tbl_i | input | 1280 | Forty 32-bit slot words, with slot k at bits [32k+31:32k] |
| result_o | output | 32 | Packed fast and normal winners |

## Verification
The bench targets slots that should be skipped: a cleared valid flag, identifiers 40 through 63, and junk in the unused middle bits. A resolver that got any of these wrong would report a source from the wrong slot, or read beyond the source vectors. Ordering is checked with a less urgent slot naming a smaller source number and with duplicate slots. A design that ranks by source number or by the last match instead of the first would report the wrong identifier. Independence between the halves is checked by adding and removing a fast winner while a normal winner is held. The bench also samples the word just before and just after the clock edge, which catches a design with missing or extra latency.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
  localparam int RES_W        = 32;
  localparam int FAST_VLD_BIT = 15;
  localparam int NORM_VLD_BIT = 31;
  localparam int NORM_ID_LSB  = 16;
  localparam logic [RES_W-1:0] RES_IDLE = 32'h003F_003F;
  typedef logic [RES_W-1:0] res_word_t;
endpackage

// File: rtl/prio_slot_match.sv
module prio_slot_match #(
  parameter int N_SRC   = 40,
  parameter int ID_W    = 6,
  parameter int ENT_W   = 32,
  parameter int VLD_BIT = 31
) (
  input  logic [ENT_W-1:0] entry_i,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] sel_i,
  output logic             fast_hit_o,
  output logic             norm_hit_o,
  output logic [ID_W-1:0]  id_o
);
  localparam int SPAN = 1 << ID_W;

  logic [SPAN-1:0] act_fast;
  logic [SPAN-1:0] act_norm;
  logic            src_ok;

  // Pad the active vectors to the full identifier span so any id indexes safely
  assign act_fast = SPAN'(pend_i & en_i & sel_i);
  assign act_norm = SPAN'(pend_i & en_i & ~sel_i);

  assign id_o       = entry_i[ID_W-1:0];
  assign src_ok     = entry_i[VLD_BIT] && (int'(id_o) < N_SRC);
  assign fast_hit_o = src_ok & act_fast[id_o];
  assign norm_hit_o = src_ok & act_norm[id_o];
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N_SLOT = 40,
  parameter int ID_W   = 6,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic [N_SLOT-1:0]      hit_i,
  input  logic [N_SLOT*ID_W-1:0] ids_i,
  output logic                   valid_o,
  output logic [SLOT_W-1:0]      slot_o,
  output logic [ID_W-1:0]        id_o
);
  // Scan from the least urgent slot upward so the lowest matching slot is left standing
  always_comb begin
    valid_o = 1'b0;
    slot_o  = '0;
    id_o    = '1;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        valid_o = 1'b1;
        slot_o  = SLOT_W'(i);
        id_o    = ids_i[i*ID_W +: ID_W];
      end
    end
  end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_res_pkg::*;
#(
  parameter int N_SRC   = 40,
  parameter int N_SLOT  = 40,
  parameter int ID_W    = 6,
  parameter int ENT_W   = 32,
  parameter int VLD_BIT = 31,
  parameter bit REG_OUT = 1'b1,
  localparam int TBL_W  = N_SLOT * ENT_W,
  localparam int SLOT_W = $clog2(N_SLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] fast_sel_i,
  input  logic [TBL_W-1:0] slot_tbl_i,
  output logic [RES_W-1:0] result_o
);
  logic [N_SLOT-1:0]      fast_hit;
  logic [N_SLOT-1:0]      norm_hit;
  logic [N_SLOT*ID_W-1:0] slot_ids;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    prio_slot_match #(
      .N_SRC(N_SRC), .ID_W(ID_W), .ENT_W(ENT_W), .VLD_BIT(VLD_BIT)
    ) u_match (
      .entry_i   (slot_tbl_i[s*ENT_W +: ENT_W]),
      .pend_i    (pend_i),
      .en_i      (en_i),
      .sel_i     (fast_sel_i),
      .fast_hit_o(fast_hit[s]),
      .norm_hit_o(norm_hit[s]),
      .id_o      (slot_ids[s*ID_W +: ID_W])
    );
  end

  logic              f_vld, n_vld;
  logic [SLOT_W-1:0] f_slot, n_slot;
  logic [ID_W-1:0]   f_id, n_id;

  prio_pick #(.N_SLOT(N_SLOT), .ID_W(ID_W)) u_pick_fast (
    .hit_i(fast_hit), .ids_i(slot_ids), .valid_o(f_vld), .slot_o(f_slot), .id_o(f_id)
  );
  prio_pick #(.N_SLOT(N_SLOT), .ID_W(ID_W)) u_pick_norm (
    .hit_i(norm_hit), .ids_i(slot_ids), .valid_o(n_vld), .slot_o(n_slot), .id_o(n_id)
  );

  res_word_t word;
  always_comb begin
    word                           = '0;
    word[FAST_VLD_BIT]             = f_vld;
    word[ID_W-1:0]                 = f_id;
    word[NORM_VLD_BIT]             = n_vld;
    word[NORM_ID_LSB +: ID_W]      = n_id;
  end

  if (REG_OUT) begin : g_reg
    res_word_t res_q;
    always_ff @(posedge clk) begin
      if (rst) res_q <= RES_IDLE;
      else     res_q <= word;
    end
    assign result_o = res_q;
  end else begin : g_comb
    assign result_o = word;
  end

  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (result_o[14:6] == '0) && (result_o[30:22] == '0));
  // R8
  fast_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !result_o[FAST_VLD_BIT] |-> (result_o[ID_W-1:0] == '1));
  // R8
  norm_empty_chk: assert property (@(posedge clk) disable iff (rst)
    !result_o[NORM_VLD_BIT] |-> (result_o[NORM_ID_LSB +: ID_W] == '1));
  // R4
  fast_win_chk: assert property (@(posedge clk) disable iff (rst)
    f_vld |-> fast_hit[f_slot]);
  // R5
  norm_win_chk: assert property (@(posedge clk) disable iff (rst)
    n_vld |-> norm_hit[n_slot]);
  // R3
  fast_first_chk: assert property (@(posedge clk) disable iff (rst)
    f_vld |-> ((fast_hit & ((N_SLOT'(1) << f_slot) - N_SLOT'(1))) == '0));
  // R3
  norm_first_chk: assert property (@(posedge clk) disable iff (rst)
    n_vld |-> ((norm_hit & ((N_SLOT'(1) << n_slot) - N_SLOT'(1))) == '0));
  // R8
  fast_none_chk: assert property (@(posedge clk) disable iff (rst)
    !f_vld |-> (fast_hit == '0));
endmodule

// File: tb/tb_prio_resolver.sv
module tb_prio_resolver;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pend = '0, en = '0, sel = '0;
  logic [31:0]   tbl [N];
  logic [N*32-1:0] tbl_flat;
  logic [31:0]   result;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) tbl_flat[i*32 +: 32] = tbl[i];

  prio_resolver dut (
    .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .fast_sel_i(sel),
    .slot_tbl_i(tbl_flat), .result_o(result)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model();
    logic [31:0] r = 32'h003F003F;
    bit fd = 0, nd = 0;
    for (int s = 0; s < N; s++) begin
      logic [5:0] id = tbl[s][5:0];
      if (tbl[s][31] && id < 6'd40) begin
        if (!fd && pend[id] && en[id] && sel[id]) begin
          fd = 1; r[15] = 1'b1; r[5:0] = id;
        end
        if (!nd && pend[id] && en[id] && !sel[id]) begin
          nd = 1; r[31] = 1'b1; r[21:16] = id;
        end
      end
    end
    return r;
  endfunction

  task automatic step(); @(negedge clk); endtask
  task automatic clear();
    for (int i = 0; i < N; i++) tbl[i] = '0;
    pend = '0; en = '0; sel = '0;
  endtask
  task automatic src(input int id, input bit fast);
    pend[id] = 1'b1; en[id] = 1'b1; sel[id] = fast;
  endtask

  task automatic t_reset();
    step();
    check("R12 reset value", result, 32'h003F003F);
    rst = 1'b0;
    step();
    check("R8 idle after reset", result, 32'h003F003F);
  endtask

  task automatic t_fast_basic();
    step(); clear(); tbl[5] = 32'h8000_000C; src(12, 1);
    step(); check("R4 R6 fast winner", result, 32'h003F800C);
    pend[12] = 1'b1; en[12] = 1'b0;
    step(); check("R4 disabled source ignored", result, 32'h003F003F);
  endtask

  task automatic t_norm_basic();
    step(); clear(); tbl[0] = 32'h8000_0021; src(33, 0);
    step(); check("R5 R7 normal winner", result, 32'h8021003F);
  endtask

  task automatic t_order();
    step(); clear(); tbl[2] = 32'h8000_0007; tbl[9] = 32'h8000_0003;
    src(7, 1); src(3, 1);
    step(); check("R3 lower slot wins", result, 32'h003F8007);
    pend[7] = 1'b0;
    step(); check("R3 next slot wins", result, 32'h003F8003);
  endtask

  task automatic t_invalid();
    step(); clear(); tbl[0] = 32'h0000_0001; tbl[1] = 32'h8000_0002;
    src(1, 0); src(2, 0);
    step(); check("R1 invalid slot skipped", result, 32'h8002003F);
  endtask

  task automatic t_range();
    step(); clear(); pend = '1; en = '1; sel = '1;
    tbl[0] = 32'h8000_0028; tbl[1] = 32'h8000_003F; tbl[3] = 32'h8000_0004;
    step(); check("R2 out of range id skipped", result, 32'h003F8004);
  endtask

  task automatic t_junk();
    step(); clear(); tbl[7] = 32'hFFFF_FFCA; src(10, 0);
    step(); check("R13 middle bits ignored", result, 32'h800A003F);
  endtask

  task automatic t_both();
    step(); clear(); tbl[1] = 32'h8000_0011; tbl[4] = 32'h8000_0020;
    src(17, 1); src(32, 0);
    step(); check("R9 both halves", result, 32'h80208011);
    pend[17] = 1'b0;
    step(); check("R9 normal kept after fast removed", result, 32'h8020003F);
    pend[32] = 1'b0; pend[17] = 1'b1;
    step(); check("R9 fast kept after normal removed", result, 32'h003F8011);
  endtask

  task automatic t_dup();
    step(); clear(); tbl[4] = 32'h8000_0009; tbl[5] = 32'h8000_0002; tbl[6] = 32'h8000_0009;
    src(9, 1); src(2, 1);
    step(); check("R11 duplicate lower slot wins", result, 32'h003F8009);
  endtask

  task automatic t_latency();
    step(); clear(); tbl[0] = 32'h8000_0005;
    step(); check("R12 settled idle", result, 32'h003F003F);
    src(5, 1);
    #2; check("R12 old value before edge", result, 32'h003F003F);
    step(); check("R12 new value after edge", result, 32'h003F8005);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      step();
      for (int i = 0; i < N; i++) tbl[i] = {$urandom} & 32'h8000_003F;
      pend = N'({$urandom, $urandom}); en = N'({$urandom, $urandom}); sel = N'({$urandom, $urandom});
      step(); check("R3 R10 random pattern", result, model());
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear();
    step(); step();
    t_reset();
    t_fast_basic();
    t_norm_basic();
    t_order();
    t_invalid();
    t_range();
    t_junk();
    t_both();
    t_dup();
    t_latency();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule